// File: doc/BRIEF.md
# Peripheral Register Space Decoder

This block sits between a processor's load/store and port-access execution units and a small bank of peripheral control and status registers. Each register can be reached in two ways. A short 6-bit port address covers 0x00 to 0x3F. A data-space address reaches the same register at the port address plus 0x20. A further extended region starting at data address 0x60 is reachable only by data-space loads and stores.

Registers in the lower half of the port range also accept single-bit set, single-bit clear and single-bit test operations. One register holds hardware status flags. Hardware raises these flags, and software clears a flag by writing a one to it. A bit set or bit clear touches only the selected bit, so the other pending flags in that register survive.

Reads and bit tests answer in the same cycle as the request. Writes take effect at the next clock edge. Unimplemented addresses and reserved bits read as zero.

Top module: `ioreg_decoder`

## Requirements
- R1: After reset every implemented register reads 0.
- R2: Command 1 (port read) and command 2 (port write) use only `addr[5:0]`. Port addresses 0x00..NLO-1 and 0x20..0x20+NHI-1 are implemented.
- R3: Command 3 (data read) and command 4 (data write) reach the register at port address P through data address P+0x20, sharing the same storage.
- R4: The extended registers at data addresses 0x60..0x60+NEXT-1 are reached only by commands 3 and 4. No port command can change or read them.
- R5: Command 5 (bit set) and command 6 (bit clear) on a port address below 0x20 change only bit `bit_sel` of the addressed register.
- R6: Command 7 (bit test) drives `bit_val` with the selected bit in the same cycle. `bit_val` is 0 for every other command.
- R7: Commands 5, 6 and 7 at a port address of 0x20 or above raise `err` in the same cycle and leave the register unchanged. `err` is 0 for all other cases.
- R8: In the flag register at port FLAG_ADDR, bits in FLAG_MASK are write-one-to-clear. A full write clears the flags whose data bit is 1 and keeps the others. A bit set on a flag clears only that flag. A bit clear on a flag has no effect.
- R9: `flag_set` bits within FLAG_MASK set the matching flags at the next edge, and this takes priority over a clear in the same cycle.
- R10: Bits in RSV_MASK always read 0. Unimplemented addresses read 0, and writes to them change nothing.
- R11: `rdata` shows the addressed register during commands 1 and 3 in the same cycle. It is 0 otherwise, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | 0 idle, 1 port read, 2 port write, 3 data read, 4 data write, 5 bit set, 6 bit clear, 7 bit test |
| addr | input | 8 | Port address in bits 5:0 or full data-space address |
| bit_sel | input | 3 | Bit index for commands 5-7 |
| wdata | input | 8 | Write data for commands 2 and 4 |
| flag_set | input | 8 | Hardware flag raise, one per bit |
| rdata | output | 8 | Read data |
| bit_val | output | 1 | Bit test result |
| err | output | 1 | Rejected bit operation |

## Verification
The bench drives directed sequences first. These cover writes through one path with readback through the other, which separates a correct 0x20 offset from a missing or doubled one. A flag register holding mixed flags and control bits gets full writes, bit sets and bit clears, which shows whether a bit operation disturbs neighbouring flags. Bit operations at 0x20 and above check that they are rejected rather than aliased. A long random mix of commands, addresses biased toward range edges, and sparse hardware flag raises then exercises the boundary addresses at NLO, NHI and NEXT. It also covers a flag raise in the same cycle as a clear.

// File: rtl/ioreg_decoder.sv
module ioreg_decoder #(
  parameter int NLO = 4,
  parameter int NHI = 2,
  parameter int NEXT = 4,
  parameter logic [5:0] FLAG_ADDR = 6'h02,
  parameter logic [7:0] FLAG_MASK = 8'h0F,
  parameter logic [7:0] RSV_MASK = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  input  logic [7:0] addr,
  input  logic [2:0] bit_sel,
  input  logic [7:0] wdata,
  input  logic [7:0] flag_set,
  output logic [7:0] rdata,
  output logic       bit_val,
  output logic       err
);
  localparam int NTOT = NLO + NHI + NEXT;
  localparam int IW = (NTOT > 1) ? $clog2(NTOT) : 1;
  localparam int FIDX = (FLAG_ADDR < 6'h20) ? int'(FLAG_ADDR) : NLO + int'(FLAG_ADDR) - 32;
  localparam logic [2:0] PRD = 3'd1, PWR = 3'd2, MRD = 3'd3, MWR = 3'd4,
                         BSET = 3'd5, BCLR = 3'd6, BTST = 3'd7;

  logic [NTOT-1:0][7:0] regs, nxt;
  logic [IW-1:0] idx;
  logic hit;
  logic [7:0] mask, val;

  wire bit_cmd  = cmd >= BSET;
  wire port_cmd = (cmd == PRD) || (cmd == PWR) || bit_cmd;
  wire [7:0] da = port_cmd ? ({2'b00, addr[5:0]} + 8'h20) : addr;
  wire bit_ok   = bit_cmd && !addr[5];
  wire wr       = hit && ((cmd == PWR) || (cmd == MWR) || (bit_ok && cmd != BTST));

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (int'(da) >= 32 && int'(da) < 32 + NLO) begin
      hit = 1'b1;
      idx = IW'(int'(da) - 32);
    end else if (int'(da) >= 64 && int'(da) < 64 + NHI) begin
      hit = 1'b1;
      idx = IW'(NLO + int'(da) - 64);
    end else if (int'(da) >= 96 && int'(da) < 96 + NEXT) begin
      hit = 1'b1;
      idx = IW'(NLO + NHI + int'(da) - 96);
    end
  end

  assign err     = bit_cmd && addr[5];
  assign rdata   = (hit && (cmd == PRD || cmd == MRD)) ? regs[idx] : 8'h00;
  assign bit_val = hit && (cmd == BTST) && !addr[5] && regs[idx][bit_sel];
  assign mask    = (cmd == BSET || cmd == BCLR) ? (8'h01 << bit_sel) : 8'hFF;
  assign val     = (cmd == BCLR) ? 8'h00 : (cmd == BSET) ? 8'hFF : wdata;

  always_comb begin
    for (int i = 0; i < NTOT; i++) begin
      logic [7:0] fm;
      fm = (i == FIDX) ? FLAG_MASK : 8'h00;
      nxt[i] = regs[i];
      if (wr && idx == IW'(i))
        nxt[i] = (((regs[i] & ~mask) | (val & mask)) & ~fm) | (regs[i] & ~(mask & val) & fm);
      nxt[i] = (nxt[i] | (flag_set & fm)) & ~RSV_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) regs <= '0;
    else        regs <= nxt;
  end
endmodule

// File: rtl/ioreg_decoder_chk.sv
module ioreg_decoder_chk #(
  parameter int NLO = 4,
  parameter int NHI = 2,
  parameter int NEXT = 4,
  parameter logic [5:0] FLAG_ADDR = 6'h02,
  parameter logic [7:0] FLAG_MASK = 8'h0F,
  parameter logic [7:0] RSV_MASK = 8'h80
) (
  input logic clk,
  input logic rst_n,
  input logic [2:0] cmd,
  input logic [7:0] flag_set,
  input logic [7:0] rdata,
  input logic bit_val,
  input logic err,
  input logic [NLO+NHI+NEXT-1:0][7:0] regs
);
  localparam int NTOT = NLO + NHI + NEXT;
  localparam int FIDX = (FLAG_ADDR < 6'h20) ? int'(FLAG_ADDR) : NLO + int'(FLAG_ADDR) - 32;

  // R10
  rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n) (rdata & RSV_MASK) == 8'h00);
  // R7
  err_bitop_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> cmd >= 3'd5);
  // R7
  rejected_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && (flag_set & FLAG_MASK) == 8'h00) |=> $stable(regs));
  // R6
  bit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd != 3'd7) |-> !bit_val);
  // R9
  flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_set & FLAG_MASK & ~RSV_MASK) != 8'h00) |=>
    ((regs[FIDX] & $past(flag_set) & FLAG_MASK & ~RSV_MASK) == ($past(flag_set) & FLAG_MASK & ~RSV_MASK)));
  // R4
  ext_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2 || cmd == 3'd5 || cmd == 3'd6) |=> $stable(regs[NTOT-1:NLO+NHI]));
endmodule

bind ioreg_decoder ioreg_decoder_chk #(
  .NLO(NLO), .NHI(NHI), .NEXT(NEXT),
  .FLAG_ADDR(FLAG_ADDR), .FLAG_MASK(FLAG_MASK), .RSV_MASK(RSV_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .flag_set(flag_set),
  .rdata(rdata), .bit_val(bit_val), .err(err), .regs(regs)
);

// File: tb/ioreg_decoder_bench.sv
`timescale 1ns/1ps
module ioreg_decoder_bench;
  localparam int NLO = 4, NHI = 2, NEXT = 4;
  localparam int FLAG_PORT = 2;
  localparam int FMASK = 8'h0F, RSV = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = '0, bit_sel = '0;
  logic [7:0] addr = '0, wdata = '0, flag_set = '0;
  logic [7:0] rdata;
  logic bit_val, err;
  int checks = 0, errors = 0;
  int model [256];
  bit done = 0;

  ioreg_decoder u_ioreg_decoder (.clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr),
    .bit_sel(bit_sel), .wdata(wdata), .flag_set(flag_set),
    .rdata(rdata), .bit_val(bit_val), .err(err));

  always #2.5 clk = ~clk;

  function automatic bit impl(int d);
    return (d >= 32 && d < 32 + NLO) || (d >= 64 && d < 64 + NHI) || (d >= 96 && d < 96 + NEXT);
  endfunction

  task automatic step(input int c, input int a, input int s, input int w, input int fs, input string tag);
    int d, er, eb, ee, cur, fm;
    bit bad;
    cmd = 3'(c); addr = 8'(a); bit_sel = 3'(s); wdata = 8'(w); flag_set = 8'(fs);
    #1;
    d = (c == 1 || c == 2 || c >= 5) ? (a % 64) + 32 : a;
    er = ((c == 1 || c == 3) && impl(d)) ? model[d] : 0;
    ee = (c >= 5 && (a % 64) >= 32) ? 1 : 0;
    eb = (c == 7 && ee == 0 && impl(d)) ? (model[d] >> s) & 1 : 0;
    checks++;
    bad = (int'(rdata) != er) || (int'(bit_val) != eb) || (int'(err) != ee);
    if (bad) begin
      errors++;
      $display("FAIL %s cmd=%0d addr=%h: rdata=%h bit=%0d err=%0d expected rdata=%h bit=%0d err=%0d",
               tag, c, a, rdata, bit_val, err, er, eb, ee);
    end
    @(posedge clk);
    if (impl(d)) begin
      cur = model[d];
      fm = (d == FLAG_PORT + 32) ? FMASK : 0;
      if (c == 2 || c == 4) begin
        for (int b = 0; b < 8; b++) begin
          if ((fm >> b) & 1) begin
            if ((w >> b) & 1) cur = cur & ~(1 << b);
          end else cur = (cur & ~(1 << b)) | (w & (1 << b));
        end
      end else if (c == 5 && ee == 0) begin
        if ((fm >> s) & 1) cur = cur & ~(1 << s);
        else cur = cur | (1 << s);
      end else if (c == 6 && ee == 0) begin
        if (((fm >> s) & 1) == 0) cur = cur & ~(1 << s);
      end
      model[d] = cur;
    end
    model[FLAG_PORT + 32] = model[FLAG_PORT + 32] | (fs & FMASK);
    for (int k = 0; k < 256; k++) model[k] = model[k] & ~RSV & 8'hFF;
    @(negedge clk);
  endtask

  function automatic int pick();
    case ($urandom % 6)
      0: return $urandom % 8;
      1: return 32 + $urandom % 8;
      2: return 64 + $urandom % 8;
      3: return 96 + $urandom % 8;
      4: return 28 + $urandom % 8;
      default: return $urandom % 256;
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state via both paths
    for (int p = 0; p < 64; p++) step(1, p, 0, 0, 0, "R1");
    for (int d = 0; d < 256; d++) step(3, d, 0, 0, 0, "R1");
    // R2 R3: write one path, read the other
    step(2, 1, 0, 8'h5A, 0, "R2");
    step(3, 8'h21, 0, 0, 0, "R3");
    step(4, 8'h40, 0, 8'h3C, 0, "R3");
    step(1, 8'h20, 0, 0, 0, "R2");
    step(1, 8'hE0, 0, 0, 0, "R2");
    // R4: extended region only through data path
    step(4, 8'h60, 0, 8'h77, 0, "R4");
    step(3, 8'h60, 0, 0, 0, "R4");
    step(2, 8'h20, 0, 8'h11, 0, "R4");
    step(3, 8'h60, 0, 0, 0, "R4");
    // R10: reserved address and reserved bit
    step(4, 8'h25, 0, 8'hFF, 0, "R10");
    step(3, 8'h25, 0, 0, 0, "R10");
    step(2, 0, 0, 8'hFF, 0, "R10");
    step(1, 0, 0, 0, 0, "R10");
    // R5 R6
    step(5, 3, 6, 0, 0, "R5");
    step(6, 3, 6, 0, 0, "R5");
    step(7, 0, 2, 0, 0, "R6");
    step(7, 0, 7, 0, 0, "R6");
    // R7: rejected bit operations
    step(5, 8'h20, 0, 0, 0, "R7");
    step(6, 8'h20, 3, 0, 0, "R7");
    step(7, 8'h21, 3, 0, 0, "R7");
    step(1, 8'h20, 0, 0, 0, "R7");
    // R8 R9: flag register
    step(0, 0, 0, 0, 8'h0F, "R9");
    step(2, FLAG_PORT, 0, 8'h50, 0, "R8");
    step(1, FLAG_PORT, 0, 0, 0, "R8");
    step(5, FLAG_PORT, 1, 0, 0, "R8");
    step(1, FLAG_PORT, 0, 0, 0, "R8");
    step(6, FLAG_PORT, 2, 0, 0, "R8");
    step(5, FLAG_PORT, 5, 0, 0, "R8");
    step(2, FLAG_PORT, 0, 8'h08, 0, "R8");
    step(1, FLAG_PORT, 0, 0, 0, "R8");
    step(5, FLAG_PORT, 0, 0, 8'h01, "R9");
    step(1, FLAG_PORT, 0, 0, 0, "R9");
    // R11: random mix
    for (int n = 0; n < 3000; n++) begin
      int c = $urandom % 8;
      step(c, pick(), $urandom % 8, $urandom % 256,
           ($urandom % 5 == 0) ? $urandom % 256 : 0, "R11");
    end
    for (int d = 0; d < 256; d++) step(3, d, 0, 0, 0, "R11");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule